// File: doc/BRIEF.md
# 1000BASE-X Receive Carrier Sense

This block decides, one code group at a time, whether the receive path of a 1000BASE-X PCS is seeing carrier. Each 10-bit code group that arrives on an even position is compared with the two encodings of the comma character K28.5. The comparison counts differing bits (Hamming distance). A code group far enough from a comma counts as carrier. The comparison uses the comma encoding that the current running disparity predicts, plus a check against both encodings.

The decoded byte and its status flags pass through the block beside the comparison. They are registered exactly as often as the carrier decision, so that a downstream receive state machine sees each byte, its flags and its carrier verdict on the same clock. Deserialization, 8b/10b decoding and the receive state machine itself sit outside the block.

Top module: `gx_carrier_sense`

## Requirements
- R1: While `rst_n` is low, every output reads zero; in particular `carrier_o` is low. Both pipeline stages are cleared.
- R2: A code group on an even position whose Hamming distance is two or more from both comma encodings gives carrier.
- R3: A code group on an even position whose distance from the expected comma encoding lies between 2 and 9 inclusive gives carrier.
- R4: A code group on an even position that equals the expected comma encoding gives no carrier. So does one that equals the opposite comma encoding, which is at distance 10.
- R5: A code group marked as an odd position (`even_i` low) never gives carrier, whatever its value.
- R6: `rd_pos_i` high selects 1100000101 as the expected comma, and low selects 0011111010; bit 9 is the leftmost digit. A code group one bit away from the selected comma gives no carrier. One bit away from the other comma gives carrier.
- R7: `carrier_o` reflects the inputs sampled exactly two rising clock edges earlier. It is neither one nor three cycles late.
- R8: `byte_o`, `is_k_o`, `cg_err_o`, `disp_err_o` and `even_o` equal the matching inputs from two rising edges earlier. They stay aligned with `carrier_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one code group per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| cg_i | input | 10 | Received code group, bit 9 first on the line |
| even_i | input | 1 | High when this code group sits on an even position |
| rd_pos_i | input | 1 | Current running disparity, high for positive |
| byte_i | input | 8 | Decoded byte for this code group |
| is_k_i | input | 1 | Decoded byte is a control character |
| cg_err_i | input | 1 | Code group is not a valid 8b/10b symbol |
| disp_err_i | input | 1 | Code group broke the running disparity rule |
| carrier_o | output | 1 | Carrier detected, two cycles after the inputs |
| byte_o | output | 8 | Byte delayed by two cycles |
| is_k_o | output | 1 | Control flag delayed by two cycles |
| cg_err_o | output | 1 | Code error flag delayed by two cycles |
| disp_err_o | output | 1 | Disparity error flag delayed by two cycles |
| even_o | output | 1 | Position flag delayed by two cycles |

## Verification
Every output, the carrier verdict as well as the forwarded byte and flags, is due on the second rising edge after its inputs are sampled. The bench drives a new vector on each falling edge. On the same falling edge it compares the outputs with the vector it drove two falling edges before, so every comparison lands half a cycle after the result settles. A separate single-cycle pulse confirms that the verdict is absent one cycle after the inputs, present after two, and gone again after three. Reset is checked half a cycle after it is asserted, since it acts asynchronously.

// File: rtl/gx_carrier_sense.sv
module gx_carrier_sense #(
  parameter int CG_W     = 10,
  parameter int BYTE_W   = 8,
  parameter int MIN_DIST = 2,
  parameter int MAX_DIST = 9,
  parameter logic [CG_W-1:0] COMMA_NEG = 10'b0011111010,
  parameter logic [CG_W-1:0] COMMA_POS = 10'b1100000101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CG_W-1:0]   cg_i,
  input  logic              even_i,
  input  logic              rd_pos_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              is_k_i,
  input  logic              cg_err_i,
  input  logic              disp_err_i,
  output logic              carrier_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              is_k_o,
  output logic              cg_err_o,
  output logic              disp_err_o,
  output logic              even_o
);

  localparam int DW = $clog2(CG_W + 1);
  localparam logic [DW-1:0] LO = DW'(MIN_DIST);
  localparam logic [DW-1:0] HI = DW'(MAX_DIST);

  function automatic logic [DW-1:0] ones(input logic [CG_W-1:0] v);
    logic [DW-1:0] n;
    n = '0;
    for (int b = 0; b < CG_W; b++) n = n + DW'(v[b]);
    return n;
  endfunction

  logic [CG_W-1:0]   s1_cg;
  logic              s1_even, s1_rd, s1_k, s1_cerr, s1_derr;
  logic [BYTE_W-1:0] s1_byte;

  logic [DW-1:0] d_neg, d_pos, d_exp;
  logic          both_far, exp_band, hit;

  assign d_neg    = ones(s1_cg ^ COMMA_NEG);
  assign d_pos    = ones(s1_cg ^ COMMA_POS);
  assign d_exp    = s1_rd ? d_pos : d_neg;
  assign both_far = (d_neg >= LO) && (d_pos >= LO);
  assign exp_band = (d_exp >= LO) && (d_exp <= HI);
  assign hit      = s1_even && (both_far || exp_band);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_cg   <= '0;
      s1_even <= 1'b0;
      s1_rd   <= 1'b0;
      s1_byte <= '0;
      s1_k    <= 1'b0;
      s1_cerr <= 1'b0;
      s1_derr <= 1'b0;
    end else begin
      s1_cg   <= cg_i;
      s1_even <= even_i;
      s1_rd   <= rd_pos_i;
      s1_byte <= byte_i;
      s1_k    <= is_k_i;
      s1_cerr <= cg_err_i;
      s1_derr <= disp_err_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carrier_o  <= 1'b0;
      byte_o     <= '0;
      is_k_o     <= 1'b0;
      cg_err_o   <= 1'b0;
      disp_err_o <= 1'b0;
      even_o     <= 1'b0;
    end else begin
      carrier_o  <= hit;
      byte_o     <= s1_byte;
      is_k_o     <= s1_k;
      cg_err_o   <= s1_cerr;
      disp_err_o <= s1_derr;
      even_o     <= s1_even;
    end
  end

endmodule

// File: rtl/gx_carrier_sense_chk.sv
module gx_carrier_sense_chk #(
  parameter int CG_W     = 10,
  parameter int BYTE_W   = 8,
  parameter int MIN_DIST = 2,
  parameter int MAX_DIST = 9,
  parameter logic [CG_W-1:0] COMMA_NEG = 10'b0011111010,
  parameter logic [CG_W-1:0] COMMA_POS = 10'b1100000101
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CG_W-1:0]   cg_i,
  input logic              even_i,
  input logic              rd_pos_i,
  input logic [BYTE_W-1:0] byte_i,
  input logic              is_k_i,
  input logic              cg_err_i,
  input logic              disp_err_i,
  input logic              carrier_o,
  input logic [BYTE_W-1:0] byte_o,
  input logic              is_k_o,
  input logic              cg_err_o,
  input logic              disp_err_o,
  input logic              even_o
);

  logic [1:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= 2'd0;
    else if (since != 2'd2) since <= since + 2'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!carrier_o && byte_o == '0 && !is_k_o && !cg_err_o && !disp_err_o && !even_o));

  assert_odd_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd2 && !$past(even_i, 2)) |-> !carrier_o);

  assert_both_far_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd2 && $past(even_i, 2)
     && $countones($past(cg_i, 2) ^ COMMA_NEG) >= MIN_DIST
     && $countones($past(cg_i, 2) ^ COMMA_POS) >= MIN_DIST) |-> carrier_o);

  // R7: verdict lands exactly two edges after the inputs
  assert_carrier_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd2) |-> carrier_o == ($past(even_i, 2)
      && $countones($past(cg_i, 2) ^ ($past(rd_pos_i, 2) ? COMMA_POS : COMMA_NEG)) >= MIN_DIST
      && $countones($past(cg_i, 2) ^ ($past(rd_pos_i, 2) ? COMMA_POS : COMMA_NEG)) <= MAX_DIST));

  assert_comma_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd2 && ($past(cg_i, 2) == COMMA_NEG || $past(cg_i, 2) == COMMA_POS)) |-> !carrier_o);

  assert_data_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd2) |-> (byte_o == $past(byte_i, 2) && is_k_o == $past(is_k_i, 2)
      && cg_err_o == $past(cg_err_i, 2) && disp_err_o == $past(disp_err_i, 2)
      && even_o == $past(even_i, 2)));

endmodule

bind gx_carrier_sense gx_carrier_sense_chk #(
  .CG_W(CG_W), .BYTE_W(BYTE_W), .MIN_DIST(MIN_DIST), .MAX_DIST(MAX_DIST),
  .COMMA_NEG(COMMA_NEG), .COMMA_POS(COMMA_POS)
) u_chk (.*);

// File: tb/tb_gx_carrier_sense.sv
`timescale 1ns/1ps
module tb_gx_carrier_sense;
  localparam time PER = 4ns;
  localparam logic [9:0] KN = 10'b0011111010;
  localparam logic [9:0] KP = 10'b1100000101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] cg_i = '0;
  logic       even_i = 1'b0, rd_pos_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       is_k_i = 1'b0, cg_err_i = 1'b0, disp_err_i = 1'b0;
  logic       carrier_o, is_k_o, cg_err_o, disp_err_o, even_o;
  logic [7:0] byte_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  gx_carrier_sense dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pop(logic [9:0] v);
    int n = 0;
    for (int b = 0; b < 10; b++) n += v[b];
    return n;
  endfunction

  task automatic drive(int i);
    cg_i       = i[9:0];
    rd_pos_i   = i[10];
    even_i     = i[11];
    byte_i     = i[9:2];
    is_k_i     = i[0];
    cg_err_i   = i[1];
    disp_err_i = i[9] ^ i[0];
  endtask

  task automatic check_vec(int i);
    logic [9:0] cg = i[9:0];
    logic rd = i[10], ev = i[11];
    int dn = pop(cg ^ KN), dp = pop(cg ^ KP);
    int d = rd ? dp : dn;
    int exp_c = (ev && d >= 2 && d <= 9) ? 1 : 0;
    if (!ev) chk("R5", carrier_o, 0);
    else if (dn == 1 || dp == 1) chk("R6", carrier_o, exp_c);
    else if (d == 0 || d == 10) chk("R4", carrier_o, 0);
    else chk("R3", carrier_o, exp_c);
    if (ev && dn >= 2 && dp >= 2) chk("R2", carrier_o, 1);
    chk("R8 byte", byte_o, i[9:2]);
    chk("R8 flags", {is_k_o, cg_err_o, disp_err_o, even_o},
        {i[0], i[1], i[9] ^ i[0], i[11]});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PER * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 carrier", carrier_o, 0);
    chk("R1 data", {byte_o, is_k_o, cg_err_o, disp_err_o, even_o}, 0);
    rst_n = 1'b1;

    // full sweep: 1024 code groups x disparity x position
    for (int i = 0; i < 4096 + 2; i++) begin
      @(negedge clk);
      if (i >= 2) check_vec(i - 2);
      if (i < 4096) drive(i);
    end

    // R7: single-cycle carrier pulse between commas
    cg_i = KN; rd_pos_i = 1'b0; even_i = 1'b1;
    repeat (3) @(negedge clk);
    cg_i = 10'b0;
    @(negedge clk);
    cg_i = KN;
    chk("R7 one cycle", carrier_o, 0);
    @(negedge clk);
    chk("R7 two cycles", carrier_o, 1);
    @(negedge clk);
    chk("R7 three cycles", carrier_o, 0);

    // R1: reset during carrier clears at once
    cg_i = 10'b0; byte_i = 8'hA5; is_k_i = 1'b1; even_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pre", carrier_o, 1);
    rst_n = 1'b0;
    #1;
    chk("R1 async carrier", carrier_o, 0);
    chk("R1 async data", {byte_o, is_k_o, even_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stage two cleared", carrier_o, 0);
    @(negedge clk);
    chk("R1 recover", carrier_o, 1);

    finish_run();
  end
endmodule